// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two table entries from memory, one after the other. The top bits of the address pick an entry in a segment table, whose location comes from a root-table base input. That entry gives the base of a per-segment page table. The middle bits then pick an entry there, and that entry gives the base of the page frame. The low bits pass through unchanged as the offset within the frame.

Requests arrive on a valid/ready channel and only one walk is in flight at a time. The request side sees back-pressure because `req_ready` stays low from the moment a request is accepted until its response has been taken. Results leave on a second valid/ready channel. A response stays on the port unchanged until the consumer raises `rsp_ready`. Each table entry carries a present flag. If either level finds that flag clear, the walk ends early and reports a fault, together with the level at which it stopped. Table memory is reached through a plain read port that has a fixed one-cycle latency.

Top module: `pt_walker`

## Requirements
- R1: The virtual address is split from the most significant bit down into segment index bits [31:21], page index bits [20:10] and offset bits [9:0].
- R2: The first memory read of a walk uses word address `root + segment index`, where `root` is the `tbl_root` value sampled when the request is accepted.
- R3: An entry is 32 bits. Bit 0 is the present flag and bits [31:10] are a base whose low 10 bits read as zero. When the segment entry is present, the second read uses word address `base + page index`.
- R4: When both entries are present, the response has `rsp_fault`=0 and `rsp_paddr` = {page-entry bits [31:10], offset bits [9:0]}.
- R5: A segment entry with bit 0 = 0 ends the walk after exactly one read, with `rsp_fault`=1 and `rsp_fault_lvl`=0.
- R6: A page entry with bit 0 = 0 ends the walk after two reads, with `rsp_fault`=1 and `rsp_fault_lvl`=1. A response without a fault always has `rsp_fault_lvl`=0.
- R7: `req_ready` is high only while idle, so one walk is accepted at a time. `rd_en` is a single-cycle pulse, `rd_data` is used one cycle later, and no read is issued while a response is pending.
- R8: `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_fault_lvl` hold steady while `rsp_valid`=1 and `rsp_ready`=0. The walker returns to idle on the cycle after the handshake.
- R9: Synchronous active-high `rst` drops any walk in progress. On the cycle after reset, `req_ready`=1, `rsp_valid`=0 and `rd_en`=0.
- R10: Changing `tbl_root` after a request is accepted has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_root | input | 32 | Word address of the segment table |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 32 | Word address of the entry to read |
| rd_data | input | 32 | Entry returned one cycle after `rd_en` |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Translated physical address (zero on fault) |
| rsp_fault | output | 1 | Walk ended on an absent entry |
| rsp_fault_lvl | output | 1 | 0 = segment level, 1 = page level |

## Verification
On every cycle the assertions check the pulse shape of `rd_en`, the absence of reads while a result is pending, the refusal of a new request straight after an acceptance, the stability of a held response, the rule that a fault level appears only with a fault, and the state after reset. Only the bench scenarios can show that addresses and entries are combined correctly. They compare the sequence of read addresses, the number of reads and the final physical address or fault level against a model computed from a table pattern. The same scenarios show that a root change after acceptance has no effect and that a walk aborted by reset leaves the walker clean.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    WK_IDLE     = 3'd0,
    WK_SEG_ISSUE = 3'd1,
    WK_SEG_WAIT = 3'd2,
    WK_PG_ISSUE = 3'd3,
    WK_PG_WAIT  = 3'd4,
    WK_RESP     = 3'd5
  } walk_state_t;

  typedef enum logic {
    LVL_SEGMENT = 1'b0,
    LVL_PAGE    = 1'b1
  } fault_level_t;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int SEG_W = 11,
  parameter int PG_W  = 11,
  parameter int OFF_W = 10,
  localparam int VA_W = SEG_W + PG_W + OFF_W
) (
  input  logic [VA_W-1:0]  vaddr,
  output logic [SEG_W-1:0] seg_idx,
  output logic [PG_W-1:0]  pg_idx,
  output logic [OFF_W-1:0] offset
);
  // Fields taken from the top of the address downward.
  assign seg_idx = vaddr[VA_W-1 -: SEG_W];
  assign pg_idx  = vaddr[OFF_W +: PG_W];
  assign offset  = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
  parameter int ENT_W = 32,
  parameter int OFF_W = 10
) (
  input  logic [ENT_W-1:0] entry,
  output logic             present,
  output logic [ENT_W-1:0] base
);
  assign present = entry[0];
  // Base field keeps its bit position; the bits below it read as zero.
  assign base = {entry[ENT_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import pt_walker_pkg::*;
#(
  parameter int SEG_W = 11,
  parameter int PG_W  = 11,
  parameter int OFF_W = 10,
  parameter int ENT_W = 32,
  localparam int VA_W = SEG_W + PG_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [ENT_W-1:0] tbl_root,
  output logic [VA_W-1:0]  va_q,
  input  logic [SEG_W-1:0] seg_idx,
  input  logic [PG_W-1:0]  pg_idx,
  input  logic [OFF_W-1:0] offset,
  input  logic             ent_present,
  input  logic [ENT_W-1:0] ent_base,
  output logic             rd_en,
  output logic [ENT_W-1:0] rd_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [ENT_W-1:0] rsp_paddr,
  output logic             rsp_fault,
  output logic             rsp_fault_lvl
);
  walk_state_t      state;
  logic [ENT_W-1:0] root_q;
  logic [ENT_W-1:0] ptbase_q;
  logic [ENT_W-1:0] paddr_q;
  logic             fault_q;
  fault_level_t     lvl_q;

  logic [ENT_W-1:0] seg_addr;
  logic [ENT_W-1:0] pg_addr;

  assign seg_addr = root_q + ENT_W'(seg_idx);
  assign pg_addr  = ptbase_q + ENT_W'(pg_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WK_IDLE;
      va_q     <= '0;
      root_q   <= '0;
      ptbase_q <= '0;
      paddr_q  <= '0;
      fault_q  <= 1'b0;
      lvl_q    <= LVL_SEGMENT;
    end else begin
      unique case (state)
        WK_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            root_q <= tbl_root;
            state  <= WK_SEG_ISSUE;
          end
        end
        WK_SEG_ISSUE: state <= WK_SEG_WAIT;
        WK_SEG_WAIT: begin
          if (!ent_present) begin
            fault_q <= 1'b1;
            lvl_q   <= LVL_SEGMENT;
            paddr_q <= '0;
            state   <= WK_RESP;
          end else begin
            ptbase_q <= ent_base;
            state    <= WK_PG_ISSUE;
          end
        end
        WK_PG_ISSUE: state <= WK_PG_WAIT;
        WK_PG_WAIT: begin
          if (!ent_present) begin
            fault_q <= 1'b1;
            lvl_q   <= LVL_PAGE;
            paddr_q <= '0;
          end else begin
            fault_q <= 1'b0;
            lvl_q   <= LVL_SEGMENT;
            paddr_q <= ent_base | ENT_W'(offset);
          end
          state <= WK_RESP;
        end
        WK_RESP: begin
          if (rsp_ready) state <= WK_IDLE;
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == WK_IDLE);
  assign rd_en         = (state == WK_SEG_ISSUE) || (state == WK_PG_ISSUE);
  assign rd_addr       = (state == WK_PG_ISSUE) ? pg_addr : seg_addr;
  assign rsp_valid     = (state == WK_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = lvl_q;

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);
  assert_no_rd_pending_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !rd_en);
  assert_single_walk_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                   && $stable(rsp_fault) && $stable(rsp_fault_lvl)));
  assert_rsp_release_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));
  assert_lvl_only_fault_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> !rsp_fault_lvl);
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_valid && !rd_en));
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int SEG_W = 11,
  parameter int PG_W  = 11,
  parameter int OFF_W = 10,
  parameter int ENT_W = 32,
  localparam int VA_W = SEG_W + PG_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [ENT_W-1:0] tbl_root,
  output logic             rd_en,
  output logic [ENT_W-1:0] rd_addr,
  input  logic [ENT_W-1:0] rd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [ENT_W-1:0] rsp_paddr,
  output logic             rsp_fault,
  output logic             rsp_fault_lvl
);
  logic [VA_W-1:0]  va_q;
  logic [SEG_W-1:0] seg_idx;
  logic [PG_W-1:0]  pg_idx;
  logic [OFF_W-1:0] offset;
  logic             ent_present;
  logic [ENT_W-1:0] ent_base;

  ptw_va_split #(.SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W)) i_split (
    .vaddr  (va_q),
    .seg_idx(seg_idx),
    .pg_idx (pg_idx),
    .offset (offset)
  );

  ptw_entry_dec #(.ENT_W(ENT_W), .OFF_W(OFF_W)) i_dec (
    .entry  (rd_data),
    .present(ent_present),
    .base   (ent_base)
  );

  ptw_ctrl #(.SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W), .ENT_W(ENT_W)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .tbl_root     (tbl_root),
    .va_q         (va_q),
    .seg_idx      (seg_idx),
    .pg_idx       (pg_idx),
    .offset       (offset),
    .ent_present  (ent_present),
    .ent_base     (ent_base),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl)
  );
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] tbl_root = '0;
  logic        rd_en;
  logic [31:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_lvl;

  int total = 0;
  int bad = 0;
  int n_rd = 0;
  logic [31:0] rd_log [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_root(tbl_root), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl)
  );

  // Table pattern: below 4096 segment entries, from 4096 page entries.
  function automatic logic [31:0] entry_at(input logic [31:0] a);
    logic [31:0] h;
    if (a < 32'd4096) begin
      h = 32'd4096 + 32'd1024 * (a % 4);
      return {h[31:10], 9'd0, ((a % 3) != 0)};
    end
    h = a * 32'h9E3779B1;
    return {h[31:10], 9'd0, ((a % 5) != 0)};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= entry_at(rd_addr);

  always @(negedge clk) if (rd_en) begin
    if (n_rd < 4) rd_log[n_rd] = rd_addr;
    n_rd = n_rd + 1;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] root, input int hold);
    logic [31:0] sa, se, pa_a, pe, exp_pa;
    logic exp_f, exp_l;
    int exp_n, t;
    logic [31:0] p0;
    logic f0, l0;
    // Model from R1..R6
    sa = root + {21'd0, va[31:21]};
    se = entry_at(sa);
    pa_a = {se[31:10], 10'd0} + {21'd0, va[20:10]};
    pe = entry_at(pa_a);
    if (!se[0]) begin exp_f = 1; exp_l = 0; exp_n = 1; exp_pa = 0; end
    else if (!pe[0]) begin exp_f = 1; exp_l = 1; exp_n = 2; exp_pa = 0; end
    else begin exp_f = 0; exp_l = 0; exp_n = 2; exp_pa = {pe[31:10], va[9:0]}; end

    @(negedge clk);
    n_rd = 0;
    req_vaddr = va; tbl_root = root; req_valid = 1;
    t = 0;
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 0;
    tbl_root = root ^ 32'h0000_0400;  // R10: change after acceptance
    check(!req_ready, "R7 busy after accept", {31'd0, req_ready}, 32'd0);
    t = 0;
    while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
    check(rsp_valid, "R7 response arrives", {31'd0, rsp_valid}, 32'd1);
    check(n_rd == exp_n, "R5 R6 read count", n_rd, exp_n);
    check(rd_log[0] == sa, "R2 R10 first read address", rd_log[0], sa);
    if (exp_n == 2) check(rd_log[1] == pa_a, "R3 second read address", rd_log[1], pa_a);
    check(rsp_fault == exp_f, "R5 R6 fault flag", {31'd0, rsp_fault}, {31'd0, exp_f});
    if (exp_f) check(rsp_fault_lvl == exp_l, exp_l ? "R6 fault level" : "R5 fault level",
                     {31'd0, rsp_fault_lvl}, {31'd0, exp_l});
    else check(rsp_paddr == exp_pa, "R4 R1 physical address", rsp_paddr, exp_pa);
    p0 = rsp_paddr; f0 = rsp_fault; l0 = rsp_fault_lvl;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == p0 && rsp_fault == f0 && rsp_fault_lvl == l0,
            "R8 response held", rsp_paddr, p0);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(req_ready && !rsp_valid, "R8 idle after handshake", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] va;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !rd_en, "R9 reset state", {31'd0, req_ready}, 32'd1);

    // Directed: segment 0 absent (0 % 3 == 0) -> R5
    walk(32'h0000_0123, 32'd0, 0);
    // Directed: segment 1 present, page-level absent or present
    walk({11'd1, 11'd0, 10'h3FF}, 32'd0, 2);
    walk({11'd1, 11'd1, 10'h001}, 32'd0, 1);
    walk({11'd2047, 11'd2047, 10'h2AA}, 32'd1024, 3);
    walk({11'd2, 11'd3, 10'h155}, 32'd0, 0);

    // R9: reset during a walk
    @(negedge clk);
    req_vaddr = {11'd1, 11'd1, 10'd0}; tbl_root = 0; req_valid = 1;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(req_ready && !rsp_valid && !rd_en, "R9 reset mid-walk", {31'd0, req_ready}, 32'd1);
    repeat (4) begin
      @(negedge clk);
      check(!rd_en && !rsp_valid, "R9 walk dropped", {31'd0, rd_en}, 32'd0);
    end

    for (int i = 0; i < 80; i++) begin
      va = $urandom;
      walk(va, ($urandom % 2) ? 32'd1024 : 32'd0, $urandom % 4);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule